// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Registers

This block is the interrupt-receiving end of one core in a multi-core system. It keeps a 32-bit pending word in which each bit marks one kind of interprocessor request. It also keeps a 32-bit enable word and eight 32-bit mailbox words, which other cores use to pass small messages. Software reaches all of this through a 32-bit register port addressed by a byte offset. Two of the offsets are write-only command ports: writing a value to one sets the written bits in the pending word, and writing a value to the other clears them. A separate sideband port lets a remote sender set pending bits directly, one pulse per request.

The interrupt line toward the core is a registered level that a small two-state machine produces. The line is re-evaluated only when a set event or a clear event happens. In state `IRQ_QUIET`, the RAISE transition to `IRQ_RAISED` fires when a set event, from the local port or the remote port, leaves `pending & enable` nonzero. In state `IRQ_RAISED`, the DROP transition back to `IRQ_QUIET` fires when a clear write leaves the pending word at zero while the enable word is nonzero. No other case moves the machine: a set that leaves `pending & enable` at zero, a change of the enable word, or a clear while enable is zero all leave the line where it was.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset the pending word, the enable word and all eight mailbox words read as zero, and `irq_o` is low.
- R2: Only the low 8 bits of `acc_offset` are decoded. An access at an offset whose low byte matches a register acts on that register, whatever the upper bits are.
- R3: A write to the set port (offset 0x08) ORs the data into the pending word, which reads at offset 0x00. The data is applied on the next rising edge. If the resulting `pending & enable` is nonzero, `irq_o` is high from that edge on.
- R4: A write to the clear port (offset 0x0C) clears the written bits of the pending word. `irq_o` goes low on that edge only if the pending word becomes zero and the enable word is nonzero. If bits remain pending, or if enable is zero, `irq_o` keeps its level.
- R5: Reads of the set and clear ports return zero. A write to the pending word at offset 0x00 is discarded.
- R6: The enable word is read and written at offset 0x04. The eight mailbox words are read and written at offsets 0x20 to 0x3F, and the word index is (offset - 0x20) >> 2, so the two low offset bits are ignored.
- R7: Reads of unmapped offsets (0x10 to 0x1F and 0x40 to 0xFF of the low byte) return zero, and writes to them change no state. The read data is also zero when no read is being made.
- R8: A pulse on `rmt_set_valid` ORs `rmt_set_bits` into the pending word and follows the same raise rule as R3. A local set write and a remote pulse in the same cycle are both ORed in. A local clear and a remote pulse in the same cycle apply the clear to the old value first and then OR in the remote bits.
- R9: A write to the enable word does not change `irq_o` by itself. The line is re-evaluated only at the next set or clear event, which uses the enable value held before that cycle.
- R10: A set event whose result ANDed with the enable word is zero leaves `irq_o` at its current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | ADDR_W (16) | Byte offset; only the low byte is decoded |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Read data, combinational from the offset during a read, else zero |
| rmt_set_valid | input | 1 | Remote set pulse |
| rmt_set_bits | input | DATA_W (32) | Bits that the remote pulse sets in the pending word |
| irq_o | output | 1 | Registered level interrupt toward the core |

## Verification
The bench walks every low-byte offset, with nonzero upper address bits, and compares all 256 read offsets against an arithmetic model after each write. This exposes a decoder that looks at too many address bits, aliases the mailboxes, or lets an unmapped or write-only offset leak state. Directed sequences go after the asymmetric interrupt rule. They clear to zero with the enable word at zero, where a symmetric design would wrongly drop the line. They clear only some bits, where a design that tests `pending & enable` would drop the line early. They enable bits that are already pending without a set event, where a continuously evaluated design would raise the line on its own. A same-cycle local and remote set, and a same-cycle local clear and remote set, catch a design that lets one source mask the other.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;

    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_PENDING = 8'h00;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 8'h04;
    localparam logic [OFF_W-1:0] OFF_SET     = 8'h08;
    localparam logic [OFF_W-1:0] OFF_CLEAR   = 8'h0C;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PENDING,
        TGT_ENABLE,
        TGT_SET,
        TGT_CLEAR,
        TGT_MAILBOX
    } reg_target_e;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MBX_WORDS = 8,
    parameter int MBX_BASE  = 32,
    localparam int IDX_W    = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] offset_i,
    output reg_target_e       target_o,
    output logic [IDX_W-1:0]  mbx_idx_o
);

    localparam logic [OFF_W-1:0] MBX_LO = OFF_W'(MBX_BASE);
    localparam logic [OFF_W-1:0] MBX_HI = OFF_W'(MBX_BASE + 4 * MBX_WORDS - 1);

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] rel;

    always_comb begin
        // Upper address bits are dropped here: only the low byte selects.
        off       = OFF_W'(offset_i);
        rel       = off - MBX_LO;
        mbx_idx_o = IDX_W'(rel >> 2);
        if (off >= MBX_LO && off <= MBX_HI) begin
            target_o = TGT_MAILBOX;
        end else begin
            unique case (off)
                OFF_PENDING: target_o = TGT_PENDING;
                OFF_ENABLE:  target_o = TGT_ENABLE;
                OFF_SET:     target_o = TGT_SET;
                OFF_CLEAR:   target_o = TGT_CLEAR;
                default:     target_o = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_mailbox_bank.sv
module ipi_mailbox_bank #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                word_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (rd_idx_i == IDX_W'(i)) rd_data_o = word_q[i];
        end
    end

endmodule

// File: rtl/ipi_irq_fsm.sv
module ipi_irq_fsm
    import ipi_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_evt_i,
    input  logic              clr_evt_i,
    input  logic [DATA_W-1:0] pending_nxt_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic              irq_o
);

    irq_state_e state_q, state_d;

    logic raise_hit;
    logic drop_hit;

    always_comb begin
        raise_hit = set_evt_i && ((pending_nxt_i & enable_i) != '0);
        drop_hit  = clr_evt_i && (pending_nxt_i == '0) && (enable_i != '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (raise_hit) state_d = IRQ_RAISED;   // RAISE
            end
            IRQ_RAISED: begin
                if (!raise_hit && drop_hit) state_d = IRQ_QUIET; // DROP
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_regs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MBX_WORDS = 8,
    parameter int MBX_BASE  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_offset,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              rmt_set_valid,
    input  logic [DATA_W-1:0] rmt_set_bits,
    output logic              irq_o
);

    localparam int IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1;

    reg_target_e       target;
    logic [IDX_W-1:0]  mbx_idx;
    logic [DATA_W-1:0] mbx_rdata;
    logic [DATA_W-1:0] pending_q, pending_nxt;
    logic [DATA_W-1:0] enable_q;
    logic              loc_wr, loc_rd;
    logic              set_wr, clr_wr, en_wr, mbx_wr;

    ipi_addr_decode #(
        .ADDR_W    (ADDR_W),
        .MBX_WORDS (MBX_WORDS),
        .MBX_BASE  (MBX_BASE)
    ) u_decode (
        .offset_i  (acc_offset),
        .target_o  (target),
        .mbx_idx_o (mbx_idx)
    );

    always_comb begin
        loc_wr = acc_valid && acc_write;
        loc_rd = acc_valid && !acc_write;
        set_wr = loc_wr && (target == TGT_SET);
        clr_wr = loc_wr && (target == TGT_CLEAR);
        en_wr  = loc_wr && (target == TGT_ENABLE);
        mbx_wr = loc_wr && (target == TGT_MAILBOX);
    end

    // Clear acts on the old value; both set sources are ORed in afterwards.
    always_comb begin
        pending_nxt = (pending_q & ~(clr_wr ? acc_wdata : '0))
                    | (set_wr ? acc_wdata : '0)
                    | (rmt_set_valid ? rmt_set_bits : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            enable_q  <= '0;
        end else begin
            pending_q <= pending_nxt;
            if (en_wr) enable_q <= acc_wdata;
        end
    end

    ipi_mailbox_bank #(
        .WORDS  (MBX_WORDS),
        .DATA_W (DATA_W)
    ) u_mbx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (mbx_wr),
        .wr_idx_i  (mbx_idx),
        .wdata_i   (acc_wdata),
        .rd_idx_i  (mbx_idx),
        .rd_data_o (mbx_rdata)
    );

    ipi_irq_fsm #(
        .DATA_W (DATA_W)
    ) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_evt_i     (set_wr || rmt_set_valid),
        .clr_evt_i     (clr_wr),
        .pending_nxt_i (pending_nxt),
        .enable_i      (enable_q),
        .irq_o         (irq_o)
    );

    always_comb begin
        acc_rdata = '0;
        if (loc_rd) begin
            unique case (target)
                TGT_PENDING: acc_rdata = pending_q;
                TGT_ENABLE:  acc_rdata = enable_q;
                TGT_MAILBOX: acc_rdata = mbx_rdata;
                default:     acc_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_offset,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              rmt_set_valid,
    input logic [DATA_W-1:0] rmt_set_bits,
    input logic              irq_o,
    input logic [DATA_W-1:0] pending_q,
    input logic [DATA_W-1:0] enable_q
);

    logic [7:0] off8;
    logic       wr, rd, set_w, clr_w;

    always_comb begin
        off8  = 8'(acc_offset);
        wr    = acc_valid && acc_write;
        rd    = acc_valid && !acc_write;
        set_w = wr && off8 == 8'h08;
        clr_w = wr && off8 == 8'h0C;
    end

    assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_w || rmt_set_valid));

    assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(clr_w) && pending_q == '0 && $past(enable_q) != '0));

    assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> ((pending_q & $past(acc_wdata)) == $past(acc_wdata)));

    assert_remote_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_set_valid |=> ((pending_q & $past(rmt_set_bits)) == $past(rmt_set_bits)));

    assert_pending_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off8 == 8'h00 && !rmt_set_valid) |=> $stable(pending_q));

    assert_wo_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (off8 == 8'h08 || off8 == 8'h0C)) |-> acc_rdata == '0);

    assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((off8 >= 8'h10 && off8 <= 8'h1F) || off8 >= 8'h40)) |-> acc_rdata == '0);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_w && !clr_w && !rmt_set_valid) |=> $stable(irq_o));

endmodule

bind ipi_core_regs ipi_core_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_offset    (acc_offset),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .rmt_set_valid (rmt_set_valid),
    .rmt_set_bits  (rmt_set_bits),
    .irq_o         (irq_o),
    .pending_q     (pending_q),
    .enable_q      (enable_q)
);

// File: tb/tb_ipi_core_regs.sv
`timescale 1ns/1ps
module tb_ipi_core_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        rmt_set_valid = 1'b0;
    logic [31:0] rmt_set_bits = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model, built from the requirements.
    logic [31:0] m_pend, m_en;
    logic [31:0] m_mbx [8];
    logic        m_irq;

    always #2.5 clk = ~clk;

    ipi_core_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .rmt_set_valid(rmt_set_valid), .rmt_set_bits(rmt_set_bits), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] o);
        if (o == 8'h00) return m_pend;
        if (o == 8'h04) return m_en;
        if (o >= 8'h20 && o <= 8'h3F) return m_mbx[(o - 8'h20) >> 2];
        return 32'h0;
    endfunction

    function automatic void model_step(input bit lset, input bit lclr, input logic [31:0] d,
                                       input bit rem, input logic [31:0] r);
        logic [31:0] nx;
        nx = (m_pend & ~(lclr ? d : 32'h0)) | (lset ? d : 32'h0) | (rem ? r : 32'h0);
        if ((lset || rem) && (nx & m_en) != 0) m_irq = 1'b1;
        else if (lclr && nx == 0 && m_en != 0) m_irq = 1'b0;
        m_pend = nx;
    endfunction

    function automatic void model_write(input logic [7:0] o, input logic [31:0] d);
        if (o == 8'h04) m_en = d;
        else if (o == 8'h08) model_step(1'b1, 1'b0, d, 1'b0, 32'h0);
        else if (o == 8'h0C) model_step(1'b0, 1'b1, d, 1'b0, 32'h0);
        else if (o >= 8'h20 && o <= 8'h3F) m_mbx[(o - 8'h20) >> 2] = d;
    endfunction

    // One cycle with an optional local write and an optional remote pulse.
    task automatic bus_cycle(input bit lw, input logic [15:0] o, input logic [31:0] d,
                             input bit rv, input logic [31:0] rb);
        @(negedge clk);
        acc_valid = lw; acc_write = lw; acc_offset = o; acc_wdata = d;
        rmt_set_valid = rv; rmt_set_bits = rb;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; rmt_set_valid = 1'b0;
        if (rv) begin
            model_step(lw && o[7:0] == 8'h08, lw && o[7:0] == 8'h0C, d, 1'b1, rb);
            if (lw && o[7:0] == 8'h04) m_en = d;
            if (lw && o[7:0] >= 8'h20 && o[7:0] <= 8'h3F) m_mbx[(o[7:0] - 8'h20) >> 2] = d;
        end else if (lw) begin
            model_write(o[7:0], d);
        end
    endtask

    task automatic wr(input logic [15:0] o, input logic [31:0] d);
        bus_cycle(1'b1, o, d, 1'b0, 32'h0);
    endtask

    task automatic rd_check(input string req, input logic [15:0] o);
        acc_valid = 1'b1; acc_write = 1'b0; acc_offset = o;
        #0.5;
        check(req, acc_rdata, model_read(o[7:0]), $sformatf("read @%h", o));
        acc_valid = 1'b0;
    endtask

    task automatic irq_check(input string req, input logic exp);
        check(req, {31'h0, irq_o}, {31'h0, exp}, "irq_o");
        check(req, {31'h0, irq_o}, {31'h0, m_irq}, "irq_o vs model");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pend = 0; m_en = 0; m_irq = 0;
        for (int i = 0; i < 8; i++) m_mbx[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, every low-byte offset
        irq_check("R1", 1'b0);
        for (int o = 0; o < 256; o++) rd_check("R1", 16'(o));
        // R7: no read strobe gives zero
        acc_offset = 16'h0000; #0.5;
        check("R7", acc_rdata, 32'h0, "idle rdata");

        // R9/R10: pending bit with enable zero, then enabling it alone
        wr(16'h0008, 32'h0000_0001);
        irq_check("R10", 1'b0);
        rd_check("R3", 16'h0000);
        wr(16'h0004, 32'h0000_0001);
        irq_check("R9", 1'b0);
        // R3: next set raises
        wr(16'h0008, 32'h0000_0002);
        irq_check("R3", 1'b1);
        check("R3", model_read(8'h00), 32'h3, "model pending");
        rd_check("R3", 16'h0000);
        // R4: partial clear keeps line, full clear drops it
        wr(16'h000C, 32'h0000_0001);
        irq_check("R4", 1'b1);
        wr(16'h000C, 32'h0000_0002);
        irq_check("R4", 1'b0);
        rd_check("R4", 16'h0000);

        // R4: clear to zero with enable zero keeps line high
        wr(16'h0004, 32'h0000_0004);
        wr(16'h0008, 32'h0000_0004);
        irq_check("R3", 1'b1);
        wr(16'h0004, 32'h0000_0000);
        irq_check("R9", 1'b1);
        wr(16'h000C, 32'h0000_0004);
        irq_check("R4", 1'b1);
        wr(16'h0004, 32'h0000_0001);
        wr(16'h000C, 32'h0000_0000);
        irq_check("R4", 1'b0);

        // R5: pending is read-only, set/clear read zero
        wr(16'h0008, 32'h0000_0010);
        wr(16'h0000, 32'hFFFF_FFFF);
        rd_check("R5", 16'h0000);
        rd_check("R5", 16'h0008);
        rd_check("R5", 16'h000C);
        wr(16'h000C, 32'hFFFF_FFFF);

        // R8: remote pulse, and together with a local set / clear
        wr(16'h0004, 32'h0000_0010);
        bus_cycle(1'b0, 16'h0, 32'h0, 1'b1, 32'h0000_0010);
        irq_check("R8", 1'b1);
        rd_check("R8", 16'h0000);
        bus_cycle(1'b1, 16'h0008, 32'h0000_0001, 1'b1, 32'h0000_0100);
        check("R8", model_read(8'h00), 32'h0000_0111, "model pending");
        rd_check("R8", 16'h0000);
        bus_cycle(1'b1, 16'h000C, 32'h0000_0111, 1'b1, 32'h0000_0001);
        check("R8", model_read(8'h00), 32'h0000_0001, "model pending");
        rd_check("R8", 16'h0000);
        irq_check("R8", 1'b1);
        wr(16'h000C, 32'h0000_0001);
        irq_check("R4", 1'b0);

        // R6: mailbox low offset bits ignored
        wr(16'h0023, 32'hA5A5_0000);
        rd_check("R6", 16'h0020);
        rd_check("R6", 16'h003D);

        // R2/R6/R7: sweep all low bytes with upper address bits set
        for (int o = 0; o < 256; o++) begin
            logic [31:0] d;
            logic [15:0] a;
            d = {8'(o), ~8'(o), 8'(o) ^ 8'h5A, 8'(o) + 8'h33};
            a = {8'(o * 7 + 1), 8'(o)};
            wr(a, d);
            irq_check("R2", m_irq);
            for (int q = 0; q < 256; q++) rd_check("R2", {8'(q + 3), 8'(q)});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule